// File: doc/BRIEF.md
# Pointer-Addressed Ethernet Controller Register File

This block is the host-facing register file of a bus-mastering Ethernet controller. The host reaches it through two 16-bit ports. The index port (port 1) holds a register pointer. The data port (port 0) reads or writes whichever register that pointer selects.

Register 0 is the command/status word, and each of its bits has its own access type. Some bits are commands that can only be set, some are flags that follow the engine state, one is an enable, and the rest are event flags cleared by writing one. The remaining registers hold configuration: the init-block address, a 3-bit bus-control field, a 64-bit logical address filter and a promiscuous-receive enable. This configuration may only change while the controller is stopped. The DMA and MAC logic report events through single-cycle pulses. The block drives command strobes back to that logic and raises one interrupt line.

Read data is registered and appears on `host_rdata` the cycle after the read access. Command strobes and the interrupt line are registered outputs.

Top module: `eth_csr_file`

## Requirements
- R1: A write to port 1 loads the low 4 bits of the write data into the register pointer, and a read of port 1 returns the pointer. Port 0 accesses go to the register the pointer selects. Read data is valid on `host_rdata` after the clock edge that samples the read, and unimplemented registers read as zero.
- R2: After reset the status word reads 0x0004 (only STOP set), the pointer and all configuration registers are zero, and `irq` is low.
- R3: Status bits 0 (INIT), 1 (STRT), 2 (STOP) and 3 (TDMD) are set by writing one, and writing zero to them has no effect. Each write of one pulses the matching `cmd_*` output high for the single cycle after the write edge.
- R4: Writing INIT and STOP together leaves the status word showing STOP and not INIT. With all other bits zero, it reads exactly 0x0004.
- R5: Setting STRT clears STOP and sets bits 4 (TXON) and 5 (RXON). Setting STOP clears STRT, INIT, TDMD, TXON, RXON and every event bit. When STRT and STOP are written together, STOP wins and no start strobe is issued.
- R6: Bits 4 (TXON), 5 (RXON), 7 (INTR) and 15 (ERR) are read-only, and writes to them are ignored.
- R7: Bit 6 (INEA) is plain read/write and is loaded on every status-word write.
- R8: Event bits 8 (IDON), 9 (TINT), 10 (RINT), 11 (MERR), 12 (MISS), 13 (CERR) and 14 (BABL) are cleared by writing one. Writing zero leaves them unchanged.
- R9: An event pulse sets its bit at the same clock edge. A pulse that coincides with a write-one-to-clear of the same bit leaves the bit set.
- R10: ERR reads as the OR of BABL, CERR, MISS and MERR. INTR reads as the OR of ERR, IDON, TINT and RINT. `irq` equals INTR AND INEA, and changes at the same edge as the status word.
- R11: Setting STOP forces register 3 (bus control: bit 2 byte swap, bit 1 address-latch control, bit 0 byte control) to zero.
- R12: Register 1 holds init address bits 15:0, register 2 holds bits 31:16, registers 8 to 11 hold filter bits 15:0 upward in 16-bit steps, and register 15 bit 15 is promiscuous enable (other bits read 0). Registers 1 to 3, 8 to 11 and 15 take writes only while STOP is set; writes at other times are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_port | input | 1 | 0 = data port, 1 = index port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| ev_idon | input | 1 | Init-done event pulse |
| ev_tint | input | 1 | Transmit-done event pulse |
| ev_rint | input | 1 | Receive-done event pulse |
| ev_merr | input | 1 | Memory-error event pulse |
| ev_miss | input | 1 | Missed-frame event pulse |
| ev_cerr | input | 1 | Collision-test error event pulse |
| ev_babl | input | 1 | Transmit babble event pulse |
| cmd_init | output | 1 | Initialise strobe |
| cmd_start | output | 1 | Start strobe |
| cmd_stop | output | 1 | Stop strobe |
| cmd_tdmd | output | 1 | Transmit-demand strobe |
| irq | output | 1 | Interrupt request |
| init_addr | output | 32 | Init-block address |
| bus_ctl | output | 3 | Bus-control field |
| addr_filter | output | 64 | Logical address filter |
| promisc | output | 1 | Promiscuous receive enable |

## Verification
The event pulse from the datapath and the host's write-one-to-clear of the same status bit can arrive at the same edge. The bench provokes this by raising a receive event during the same cycle in which it writes the clear for that bit. The bit must read back as set, and a later clear with no pulse must remove it. A second collision is a STOP command issued together with STRT or INIT. That write must end with only STOP visible, no start strobe, the bus-control field at zero and all event flags gone.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
  localparam int DW = 16;

  // status word bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_TXON = 4;
  localparam int B_RXON = 5;
  localparam int B_INEA = 6;
  localparam int B_INTR = 7;
  localparam int B_ERR  = 15;

  // event flags occupy a contiguous field starting here
  localparam int EV_LO = 8;
  localparam int EV_N  = 7;
  // event index inside that field: 0 idon,1 tint,2 rint,3 merr,4 miss,5 cerr,6 babl
  localparam int EV_ERR_LO = 3;

  // register indices
  localparam int IDX_STAT    = 0;
  localparam int IDX_IADR_LO = 1;
  localparam int IDX_IADR_HI = 2;
  localparam int IDX_BCTL    = 3;
  localparam int IDX_FILT    = 8;
  localparam int IDX_MODE    = 15;

  localparam int BCTL_W      = 3;
  localparam int PROMISC_BIT = 15;
endpackage

// File: rtl/eth_csr_port.sv
module eth_csr_port
  import eth_csr_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             we,
  input  logic             port,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    stat_rd,
  input  logic [DW-1:0]    cfg_rd,
  output logic [PTR_W-1:0] ptr_q,
  output logic             stat_we,
  output logic             cfg_we,
  output logic [DW-1:0]    rdata_q
);
  logic data_we;
  logic sel_stat;

  assign data_we  = cs & we & ~port;
  assign sel_stat = (ptr_q == PTR_W'(IDX_STAT));
  assign stat_we  = data_we & sel_stat;
  assign cfg_we   = data_we & ~sel_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (cs && we && port) begin
      ptr_q <= wdata[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cs && !we) begin
      if (port)          rdata_q <= DW'(ptr_q);
      else if (sel_stat) rdata_q <= stat_rd;
      else               rdata_q <= cfg_rd;
    end
  end
endmodule

// File: rtl/eth_csr_status.sv
module eth_csr_status
  import eth_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic [EV_N-1:0] ev_in,
  output logic [DW-1:0]   stat_word,
  output logic            stop_cmd,
  output logic            stopped,
  output logic            irq_q,
  output logic            cmd_init,
  output logic            cmd_start,
  output logic            cmd_stop,
  output logic            cmd_tdmd
);
  logic            init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, inea_q;
  logic [EV_N-1:0] ev_q;

  logic [DW-1:0]   w1;
  logic            start_cmd, init_cmd, tdmd_cmd;
  logic [EV_N-1:0] ev_d;
  logic            inea_d, err_d, intr_d, err_q, intr_q;
  logic            init_d, strt_d, stop_d, tdmd_d, txon_d, rxon_d;

  always_comb begin
    w1        = wr_en ? wdata : '0;
    stop_cmd  = w1[B_STOP];
    // a stop request overrides every other command in the same write
    start_cmd = w1[B_STRT] & ~stop_cmd;
    init_cmd  = w1[B_INIT] & ~stop_cmd;
    tdmd_cmd  = w1[B_TDMD] & ~stop_cmd;

    // a pulse beats a simultaneous clear; stop wipes everything
    ev_d   = stop_cmd ? '0 : ((ev_q & ~w1[EV_LO +: EV_N]) | ev_in);
    inea_d = wr_en ? wdata[B_INEA] : inea_q;
    err_d  = |ev_d[EV_N-1:EV_ERR_LO];
    intr_d = err_d | (|ev_d[EV_ERR_LO-1:0]);

    init_d = init_q; strt_d = strt_q; stop_d = stop_q;
    tdmd_d = tdmd_q; txon_d = txon_q; rxon_d = rxon_q;
    if (stop_cmd) begin
      init_d = 1'b0; strt_d = 1'b0; stop_d = 1'b1;
      tdmd_d = 1'b0; txon_d = 1'b0; rxon_d = 1'b0;
    end else begin
      if (init_cmd) init_d = 1'b1;
      if (tdmd_cmd) tdmd_d = 1'b1;
      if (start_cmd) begin
        strt_d = 1'b1; stop_d = 1'b0;
        txon_d = 1'b1; rxon_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b0; strt_q <= 1'b0; stop_q <= 1'b1; tdmd_q <= 1'b0;
      txon_q <= 1'b0; rxon_q <= 1'b0; inea_q <= 1'b0;
      ev_q   <= '0;
      irq_q  <= 1'b0;
      cmd_init <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_tdmd <= 1'b0;
    end else begin
      init_q <= init_d; strt_q <= strt_d; stop_q <= stop_d; tdmd_q <= tdmd_d;
      txon_q <= txon_d; rxon_q <= rxon_d; inea_q <= inea_d;
      ev_q   <= ev_d;
      irq_q  <= intr_d & inea_d;
      cmd_init  <= init_cmd;
      cmd_start <= start_cmd;
      cmd_stop  <= stop_cmd;
      cmd_tdmd  <= tdmd_cmd;
    end
  end

  assign err_q  = |ev_q[EV_N-1:EV_ERR_LO];
  assign intr_q = err_q | (|ev_q[EV_ERR_LO-1:0]);
  assign stopped = stop_q;

  always_comb begin
    stat_word                  = '0;
    stat_word[B_INIT]          = init_q;
    stat_word[B_STRT]          = strt_q;
    stat_word[B_STOP]          = stop_q;
    stat_word[B_TDMD]          = tdmd_q;
    stat_word[B_TXON]          = txon_q;
    stat_word[B_RXON]          = rxon_q;
    stat_word[B_INEA]          = inea_q;
    stat_word[B_INTR]          = intr_q;
    stat_word[EV_LO +: EV_N]   = ev_q;
    stat_word[B_ERR]           = err_q;
  end
endmodule

// File: rtl/eth_csr_cfg.sv
module eth_csr_cfg
  import eth_csr_pkg::*;
#(
  parameter int PTR_W      = 4,
  parameter int FILT_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [DW-1:0]            wdata,
  input  logic                     stopped,
  input  logic                     stop_cmd,
  output logic [2*DW-1:0]          iadr,
  output logic [BCTL_W-1:0]        bctl,
  output logic [FILT_WORDS*DW-1:0] filt,
  output logic                     promisc,
  output logic [DW-1:0]            rd_data
);
  logic lw;
  assign lw = wr_en & stopped;

  logic [DW-1:0] iadr_lo_q, iadr_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      iadr_lo_q <= '0;
      iadr_hi_q <= '0;
      promisc   <= 1'b0;
    end else if (lw) begin
      if (ptr == PTR_W'(IDX_IADR_LO)) iadr_lo_q <= wdata;
      if (ptr == PTR_W'(IDX_IADR_HI)) iadr_hi_q <= wdata;
      if (ptr == PTR_W'(IDX_MODE))    promisc   <= wdata[PROMISC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stop_cmd) begin
      bctl <= '0;
    end else if (lw && ptr == PTR_W'(IDX_BCTL)) begin
      bctl <= wdata[BCTL_W-1:0];
    end
  end

  assign iadr = {iadr_hi_q, iadr_lo_q};

  for (genvar g = 0; g < FILT_WORDS; g++) begin : g_filt
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (lw && ptr == PTR_W'(IDX_FILT + g)) begin
        word_q <= wdata;
      end
    end
    assign filt[g*DW +: DW] = word_q;
  end

  always_comb begin
    rd_data = '0;
    if (ptr == PTR_W'(IDX_IADR_LO)) rd_data = iadr_lo_q;
    if (ptr == PTR_W'(IDX_IADR_HI)) rd_data = iadr_hi_q;
    if (ptr == PTR_W'(IDX_BCTL))    rd_data = DW'(bctl);
    if (ptr == PTR_W'(IDX_MODE))    rd_data[PROMISC_BIT] = promisc;
    for (int k = 0; k < FILT_WORDS; k++) begin
      if (ptr == PTR_W'(IDX_FILT + k)) rd_data = filt[k*DW +: DW];
    end
  end
endmodule

// File: rtl/eth_csr_file.sv
module eth_csr_file
  import eth_csr_pkg::*;
#(
  parameter int PTR_W      = 4,
  parameter int FILT_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_cs,
  input  logic                     host_we,
  input  logic                     host_port,
  input  logic [DW-1:0]            host_wdata,
  output logic [DW-1:0]            host_rdata,
  input  logic                     ev_idon,
  input  logic                     ev_tint,
  input  logic                     ev_rint,
  input  logic                     ev_merr,
  input  logic                     ev_miss,
  input  logic                     ev_cerr,
  input  logic                     ev_babl,
  output logic                     cmd_init,
  output logic                     cmd_start,
  output logic                     cmd_stop,
  output logic                     cmd_tdmd,
  output logic                     irq,
  output logic [2*DW-1:0]          init_addr,
  output logic [BCTL_W-1:0]        bus_ctl,
  output logic [FILT_WORDS*DW-1:0] addr_filter,
  output logic                     promisc
);
  logic [PTR_W-1:0] ptr_q;
  logic             stat_we, cfg_we;
  logic [DW-1:0]    stat_word, cfg_rd;
  logic             stop_cmd, stopped;
  logic [EV_N-1:0]  ev_vec;

  assign ev_vec = {ev_babl, ev_cerr, ev_miss, ev_merr, ev_rint, ev_tint, ev_idon};

  eth_csr_port #(.PTR_W(PTR_W)) u_port (
    .clk(clk), .rst(rst), .cs(host_cs), .we(host_we), .port(host_port),
    .wdata(host_wdata), .stat_rd(stat_word), .cfg_rd(cfg_rd),
    .ptr_q(ptr_q), .stat_we(stat_we), .cfg_we(cfg_we), .rdata_q(host_rdata)
  );

  eth_csr_status u_stat (
    .clk(clk), .rst(rst), .wr_en(stat_we), .wdata(host_wdata), .ev_in(ev_vec),
    .stat_word(stat_word), .stop_cmd(stop_cmd), .stopped(stopped), .irq_q(irq),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_tdmd(cmd_tdmd)
  );

  eth_csr_cfg #(.PTR_W(PTR_W), .FILT_WORDS(FILT_WORDS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .ptr(ptr_q), .wdata(host_wdata),
    .stopped(stopped), .stop_cmd(stop_cmd), .iadr(init_addr), .bctl(bus_ctl),
    .filt(addr_filter), .promisc(promisc), .rd_data(cfg_rd)
  );
endmodule

// File: rtl/eth_csr_chk.sv
module eth_csr_chk
  import eth_csr_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               host_cs,
  input logic               host_we,
  input logic               host_port,
  input logic [DW-1:0]      host_wdata,
  input logic [PTR_W-1:0]   ptr_q,
  input logic [DW-1:0]      stat_word,
  input logic               irq,
  input logic               cmd_start,
  input logic               cmd_stop,
  input logic [BCTL_W-1:0]  bus_ctl,
  input logic [2*DW-1:0]    init_addr,
  input logic               ev_tint
);
  logic sw;
  assign sw = host_cs && host_we && !host_port && (ptr_q == PTR_W'(IDX_STAT));

  // R4: init together with stop leaves stop only
  a_r4_init_hidden: assert property (@(posedge clk) disable iff (rst)
    (sw && host_wdata[B_INIT] && host_wdata[B_STOP]) |=> (stat_word[B_STOP] && !stat_word[B_INIT]));

  // R11: stop forces bus control to zero
  a_r11_stop_busctl: assert property (@(posedge clk) disable iff (rst)
    (sw && host_wdata[B_STOP]) |=> (bus_ctl == '0));

  // R9: transmit event sets its flag unless a stop is written alongside
  a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_tint && !(sw && host_wdata[B_STOP])) |=> stat_word[EV_LO + 1]);

  // R10: interrupt only with enable and a pending cause
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_word[B_INEA] && stat_word[B_INTR]));

  // R12: configuration frozen while running
  a_r12_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    !stat_word[B_STOP] |=> $stable(init_addr));

  // R5: start and stop strobes never together; running excludes stopped
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(cmd_start && cmd_stop));
  a_r5_txon_running: assert property (@(posedge clk) disable iff (rst)
    stat_word[B_TXON] |-> !stat_word[B_STOP]);
endmodule

bind eth_csr_file eth_csr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
  .host_port(host_port), .host_wdata(host_wdata), .ptr_q(ptr_q),
  .stat_word(stat_word), .irq(irq), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .bus_ctl(bus_ctl), .init_addr(init_addr),
  .ev_tint(ev_tint)
);

// File: tb/sim_eth_csr_file.sv
module sim_eth_csr_file;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;
  localparam logic [1:0] W = 2'd0, R = 2'd1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_cs = 1'b0, host_we = 1'b0, host_port = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic ev_idon = 0, ev_tint = 0, ev_rint = 0, ev_merr = 0, ev_miss = 0, ev_cerr = 0, ev_babl = 0;
  logic cmd_init, cmd_start, cmd_stop, cmd_tdmd, irq, promisc;
  logic [31:0] init_addr;
  logic [2:0]  bus_ctl;
  logic [63:0] addr_filter;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_csr_file u0 (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_idon(ev_idon), .ev_tint(ev_tint), .ev_rint(ev_rint), .ev_merr(ev_merr),
    .ev_miss(ev_miss), .ev_cerr(ev_cerr), .ev_babl(ev_babl),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_tdmd(cmd_tdmd), .irq(irq), .init_addr(init_addr), .bus_ctl(bus_ctl),
    .addr_filter(addr_filter), .promisc(promisc)
  );

  // {req[3:0], op[1:0], port, data[15:0], expect[15:0]}
  localparam logic [38:0] TBL [NV] = '{
    {4'd2,  R, 1'b1, 16'h0000, 16'h0000},  // R2 pointer reset
    {4'd2,  R, 1'b0, 16'h0000, 16'h0004},  // R2 status reset
    {4'd1,  W, 1'b1, 16'h0001, 16'h0000},
    {4'd1,  R, 1'b1, 16'h0000, 16'h0001},  // R1 pointer readback
    {4'd12, W, 1'b0, 16'h1234, 16'h0000},
    {4'd12, R, 1'b0, 16'h0000, 16'h1234},  // R12 init addr low
    {4'd1,  W, 1'b1, 16'h0003, 16'h0000},
    {4'd11, W, 1'b0, 16'h0007, 16'h0000},
    {4'd11, R, 1'b0, 16'h0000, 16'h0007},  // R11 bus control writable when stopped
    {4'd1,  W, 1'b1, 16'h000F, 16'h0000},
    {4'd12, W, 1'b0, 16'hFFFF, 16'h0000},
    {4'd12, R, 1'b0, 16'h0000, 16'h8000},  // R12 mode reg keeps only bit 15
    {4'd1,  W, 1'b1, 16'h0008, 16'h0000},
    {4'd12, W, 1'b0, 16'hA5A5, 16'h0000},
    {4'd12, R, 1'b0, 16'h0000, 16'hA5A5},  // R12 filter word 0
    {4'd1,  W, 1'b1, 16'h0000, 16'h0000},
    {4'd5,  W, 1'b0, 16'h0002, 16'h0000},
    {4'd5,  R, 1'b0, 16'h0000, 16'h0032},  // R5 start: STRT TXON RXON, STOP gone
    {4'd1,  W, 1'b1, 16'h0001, 16'h0000},
    {4'd12, W, 1'b0, 16'hBEEF, 16'h0000},
    {4'd12, R, 1'b0, 16'h0000, 16'h1234},  // R12 write ignored while running
    {4'd1,  W, 1'b1, 16'h0000, 16'h0000},
    {4'd3,  W, 1'b0, 16'h0000, 16'h0000},
    {4'd3,  R, 1'b0, 16'h0000, 16'h0032},  // R3 zero writes no effect
    {4'd6,  W, 1'b0, 16'h80B0, 16'h0000},
    {4'd6,  R, 1'b0, 16'h0000, 16'h0032},  // R6 read-only bits
    {4'd7,  W, 1'b0, 16'h0040, 16'h0000},
    {4'd7,  R, 1'b0, 16'h0000, 16'h0072},  // R7 INEA set
    {4'd7,  W, 1'b0, 16'h0000, 16'h0000},
    {4'd3,  W, 1'b0, 16'h0008, 16'h0000},
    {4'd3,  R, 1'b0, 16'h0000, 16'h003A},  // R3 TDMD set, INEA cleared (R7)
    {4'd4,  W, 1'b0, 16'h0005, 16'h0000},
    {4'd4,  R, 1'b0, 16'h0000, 16'h0004},  // R4 init+stop shows stop only
    {4'd1,  W, 1'b1, 16'h0003, 16'h0000},
    {4'd11, R, 1'b0, 16'h0000, 16'h0000},  // R11 stop cleared bus control
    {4'd1,  W, 1'b1, 16'h0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [15:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_port = port; host_wdata = d;
    @(posedge clk); #1;
    host_cs = 0; host_we = 0;
  endtask

  task automatic rd(input logic port, input logic [15:0] exp, input string tag);
    @(negedge clk);
    host_cs = 1; host_we = 0; host_port = port;
    @(posedge clk); #1;
    host_cs = 0;
    check(tag, 64'(host_rdata), 64'(exp));
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R2 irq reset", 64'(irq), 64'd0);
    check("R2 bus_ctl reset", 64'(bus_ctl), 64'd0);
    check("R2 init_addr reset", 64'(init_addr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][34:33] == W) wr(TBL[i][32], TBL[i][31:16]);
      else rd(TBL[i][32], TBL[i][15:0], $sformatf("R%0d table entry %0d", TBL[i][38:35], i));
    end

    // R12 more config, still stopped, pointer 0
    wr(1, 16'h0009); wr(0, 16'h1111);
    check("R12 filter low words", addr_filter[31:0], 64'h1111A5A5);
    wr(1, 16'h0002); wr(0, 16'hCAFE);
    check("R12 init_addr", 64'(init_addr), 64'hCAFE1234);
    check("R12 promisc", 64'(promisc), 64'd1);
    wr(1, 16'h0000);

    // R3 strobes
    wr(0, 16'h0002);
    check("R3 start strobe", 64'(cmd_start), 64'd1);
    idle();
    check("R3 start strobe one cycle", 64'(cmd_start), 64'd0);
    wr(0, 16'h0001);
    check("R3 init strobe", 64'(cmd_init), 64'd1);
    wr(0, 16'h0008);
    check("R3 tdmd strobe", 64'(cmd_tdmd), 64'd1);
    rd(0, 16'h003B, "R3 status after commands");

    // R12 locked while running
    wr(1, 16'h000F); wr(0, 16'h0000);
    check("R12 promisc locked", 64'(promisc), 64'd1);
    wr(1, 16'h0003); wr(0, 16'h0005);
    check("R12 bus_ctl locked", 64'(bus_ctl), 64'd0);

    // R11 stop clears bus control
    wr(1, 16'h0000); wr(0, 16'h0004);
    check("R3 stop strobe", 64'(cmd_stop), 64'd1);
    wr(1, 16'h0003); wr(0, 16'h0007);
    check("R11 bus_ctl loaded", 64'(bus_ctl), 64'd7);
    wr(1, 16'h0000); wr(0, 16'h0002);
    check("R11 bus_ctl kept by start", 64'(bus_ctl), 64'd7);
    wr(0, 16'h0004);
    check("R11 bus_ctl cleared by stop", 64'(bus_ctl), 64'd0);

    // R8 / R10 event and interrupt
    @(negedge clk); ev_tint = 1; @(posedge clk); #1 ev_tint = 0;
    rd(0, 16'h0284, "R9 tint sets, R10 INTR");
    check("R10 irq masked", 64'(irq), 64'd0);
    wr(0, 16'h0040);
    check("R10 irq enabled", 64'(irq), 64'd1);
    rd(0, 16'h02C4, "R8 zero write keeps flag");
    wr(0, 16'h0240);
    check("R10 irq after clear", 64'(irq), 64'd0);
    rd(0, 16'h0044, "R8 tint cleared");

    // R9 pulse beats simultaneous clear
    @(negedge clk);
    ev_rint = 1; host_cs = 1; host_we = 1; host_port = 0; host_wdata = 16'h0440;
    @(posedge clk); #1;
    ev_rint = 0; host_cs = 0; host_we = 0;
    rd(0, 16'h04C4, "R9 pulse wins over clear");
    wr(0, 16'h0440);
    rd(0, 16'h0044, "R8 rint cleared");

    // R10 error summary
    @(negedge clk); ev_babl = 1; @(posedge clk); #1 ev_babl = 0;
    rd(0, 16'hC0C4, "R10 ERR from BABL");
    check("R10 irq on error", 64'(irq), 64'd1);
    @(negedge clk); ev_merr = 1; @(posedge clk); #1 ev_merr = 0;
    wr(0, 16'h4040);
    rd(0, 16'h88C4, "R10 ERR from MERR");
    wr(0, 16'h0044);
    check("R5 stop clears events irq", 64'(irq), 64'd0);
    rd(0, 16'h0044, "R5 stop clears events");

    // R5 stop wins over start
    wr(0, 16'h0006);
    check("R5 no start strobe", 64'(cmd_start), 64'd0);
    check("R5 stop strobe", 64'(cmd_stop), 64'd1);
    rd(0, 16'h0004, "R5 stop wins");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule